// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator Unit

This block watches the instruction fetch address and raises a breakpoint hit when the address matches one of a set of programmable comparators. It has a small register bank: one control word at byte offset 0x0 and one word per comparator at byte offsets 0x8, 0xC, 0x10 and so on. The control word holds a global enable and reports how many comparators exist and which comparator format is built.

The comparator format is fixed by a parameter. The narrow format matches only the low 512 MiB of the address space. It compares bits [28:2] and uses a two-bit selector to pick the lower half-word, the upper half-word or both half-words of the addressed word. The wide format compares address bits [31:1] across the full 4 GiB space. The hit output is combinational from the fetch inputs, so halt logic downstream can act in the same cycle. The hit also comes with the index of the lowest-numbered matching comparator.

Top module: `iabp_unit`

## Requirements
- R1: After reset the global enable reads 0, every comparator word reads 0 and no hit is raised.
- R2: A write to the control word (offset 0x0) with bit 1 equal to 0 changes nothing. With bit 1 equal to 1, the write loads bit 0 into the global enable.
- R3: The control word reads back as follows. Bits [31:28] hold the format (0 narrow, 1 wide). The comparator count has its upper three bits in [14:12] and its lower four bits in [7:4]. Bits [11:8] read 0. Bit 0 holds the global enable. All other bits read 0.
- R4: Comparator i sits at byte offset 8+4*i. It stores the full 32-bit value written and reads that value back. Bit 0 of the word is the comparator's own enable.
- R5: Offset 0x4, offsets past the last comparator and offsets with bits [1:0] not equal to 0 read as 0, and writes to them have no effect.
- R6: In the narrow format a comparator matches only when all of these hold: fetch bits [31:29] are 0, fetch bits [28:2] equal comparator bits [28:2], and the selector in comparator bits [31:30] accepts the half-word. Selector 01 accepts fetch bit 1 = 0. Selector 10 accepts fetch bit 1 = 1. Selector 11 accepts both. Selector 00 never matches. Fetch bit 0 is ignored.
- R7: In the wide format a comparator matches when fetch bits [31:1] equal comparator bits [31:1].
- R8: The hit is raised in the same cycle as the fetch. It requires fetch_valid, the global enable and at least one enabled, matching comparator.
- R9: When the hit is raised, the hit index is the lowest-numbered matching comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch byte address |
| bp_hit | output | 1 | Breakpoint hit |
| bp_idx | output | IDX_W | Lowest matching comparator index |

## Verification
Both formats are built side by side in a four-comparator configuration. In the narrow format, all four selector values are swept against all four values of the fetch address's low two bits. This separates the lower-half, upper-half, both and never cases. Fetches with a high bit set check that the 512 MiB limit is applied. In the wide format, fetch offsets around a programmed address check that bit 0 is ignored and bit 1 is not. Overlapping comparators, enabled and disabled in turn, check the lowest-index rule. Keyless control writes and writes to gaps show whether stray accesses are ignored.

// File: rtl/iabp_pkg.sv
package iabp_pkg;
    localparam int WORD_W = 32;

    // Narrow format: low 512 MiB only, half-word selector in bits [31:30]
    function automatic logic narrow_match(input logic [WORD_W-1:0] c,
                                          input logic [WORD_W-1:0] a);
        logic sel_ok;
        sel_ok = a[1] ? c[31] : c[30];
        return (a[31:29] == 3'b000) && (a[28:2] == c[28:2]) && sel_ok;
    endfunction

    // Wide format: half-word granularity across the full space
    function automatic logic wide_match(input logic [WORD_W-1:0] c,
                                        input logic [WORD_W-1:0] a);
        return a[31:1] == c[31:1];
    endfunction
endpackage

// File: rtl/iabp_regs.sv
module iabp_regs
    import iabp_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int FMT     = 0,
    parameter int REG_AW  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [REG_AW-1:0]             addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W-1:0]             rdata,
    output logic                          gen_en,
    output logic [NUM_CMP-1:0][WORD_W-1:0] cmp_words
);
    localparam int       SLOT_W = REG_AW - 2;
    localparam logic [6:0] CNT  = 7'(NUM_CMP);

    typedef struct packed {
        logic                           en;
        logic [NUM_CMP-1:0][WORD_W-1:0] cmp;
    } regs_t;

    regs_t              st_d, st_q;
    logic [SLOT_W-1:0]  word;
    logic               aligned;

    assign word    = addr[REG_AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        if (aligned && word == '0) begin
            rdata[31:28] = 4'(FMT);
            rdata[14:12] = CNT[6:4];
            rdata[7:4]   = CNT[3:0];
            rdata[0]     = st_q.en;
            if (we && wdata[1]) st_d.en = wdata[0];
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (aligned && word == SLOT_W'(i + 2)) begin
                rdata = st_q.cmp[i];
                if (we) st_d.cmp[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gen_en    = st_q.en;
    assign cmp_words = st_q.cmp;

    p_keyless_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == '0 && !wdata[1]) |=> $stable(gen_en));

    p_keyed_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == '0 && wdata[1]) |=> (gen_en == $past(wdata[0])));

    p_gap_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == REG_AW'(4)) |=> ($stable(cmp_words) && $stable(gen_en)));
endmodule

// File: rtl/iabp_cmp.sv
module iabp_cmp
    import iabp_pkg::*;
#(
    parameter int FMT = 0
) (
    input  logic [WORD_W-1:0] cmp_word,
    input  logic [WORD_W-1:0] fetch_addr,
    output logic              match
);
    generate
        if (FMT == 0) begin : g_narrow
            logic unused_bits;
            assign unused_bits = ^{fetch_addr[0], cmp_word[29], cmp_word[1]};
            assign match = cmp_word[0] && narrow_match(cmp_word, fetch_addr);
        end else begin : g_wide
            logic unused_bits;
            assign unused_bits = fetch_addr[0];
            assign match = cmp_word[0] && wide_match(cmp_word, fetch_addr);
        end
    endgenerate
endmodule

// File: rtl/iabp_prio.sv
module iabp_prio #(
    parameter int N    = 4,
    parameter int IW   = 2
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/iabp_unit.sv
module iabp_unit
    import iabp_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int FMT     = 0,
    parameter int REG_AW  = 8,
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    output logic              bp_hit,
    output logic [IDX_W-1:0]  bp_idx
);
    logic                           gen_en;
    logic [NUM_CMP-1:0][WORD_W-1:0] cmp_words;
    logic [NUM_CMP-1:0]             match_vec;
    logic                           any_match;

    iabp_regs #(.NUM_CMP(NUM_CMP), .FMT(FMT), .REG_AW(REG_AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .gen_en(gen_en),
        .cmp_words(cmp_words)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        iabp_cmp #(.FMT(FMT)) cmp_i (
            .cmp_word(cmp_words[g]), .fetch_addr(fetch_addr),
            .match(match_vec[g])
        );
    end

    iabp_prio #(.N(NUM_CMP), .IW(IDX_W)) prio_i (
        .vec(match_vec), .any(any_match), .idx(bp_idx)
    );

    assign bp_hit = fetch_valid && gen_en && any_match;

    p_hit_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> (fetch_valid && gen_en));

    p_idx_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> match_vec[bp_idx]);

    p_idx_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_hit && bp_idx != '0) |-> !match_vec[0]);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !bp_hit);
endmodule

// File: tb/iabp_unit_tb.sv
module iabp_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we0 = 1'b0, we1 = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        fv = 1'b0;
    logic [31:0] fa = '0;
    logic        hit0, hit1;
    logic [1:0]  idx0, idx1;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iabp_unit #(.NUM_CMP(N), .FMT(0), .REG_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(we0), .cfg_addr(addr),
        .cfg_wdata(wdata), .cfg_rdata(rd0), .fetch_valid(fv),
        .fetch_addr(fa), .bp_hit(hit0), .bp_idx(idx0));

    iabp_unit #(.NUM_CMP(N), .FMT(1), .REG_AW(AW)) dut1_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(we1), .cfg_addr(addr),
        .cfg_wdata(wdata), .cfg_rdata(rd1), .fetch_valid(fv),
        .fetch_addr(fa), .bp_hit(hit1), .bp_idx(idx1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (which == 0) we0 = 1'b1; else we1 = 1'b1;
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a);
        @(negedge clk);
        addr = a;
        #1;
    endtask

    task automatic fetch(input logic v, input logic [31:0] a);
        @(negedge clk);
        fv = v; fa = a;
        #1;
    endtask

    function automatic logic exp_narrow(input logic [31:0] c, input logic [31:0] a);
        logic [31:0] sel;
        sel = c >> 30;
        if ((a >> 29) != 0) return 1'b0;
        if (((a >> 2) & 32'h07FF_FFFF) != ((c >> 2) & 32'h07FF_FFFF)) return 1'b0;
        if ((c & 1) == 0) return 1'b0;
        return ((a & 2) != 0) ? ((sel & 2) != 0) : ((sel & 1) != 0);
    endfunction

    function automatic logic [31:0] exp_ctrl(input int fmt, input int en);
        return (32'(fmt) << 28) | (32'((N >> 4) & 7) << 12) | (32'(N & 15) << 4) | 32'(en);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] base, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        look(8'h00);
        check("R1 ctrl0", rd0, exp_ctrl(0, 0));
        check("R1 ctrl1", rd1, exp_ctrl(1, 0));
        for (int i = 0; i < N; i++) begin
            look(AW'(8 + 4 * i));
            check("R1 cmp zero", rd0, 32'h0);
        end
        fetch(1'b1, 32'h0);
        check("R1 no hit", {31'b0, hit0}, 32'h0);

        // R4: read back of each slot
        for (int i = 0; i < N; i++) begin
            wr(0, AW'(8 + 4 * i), 32'hA5A5_0000 + 32'(i));
            look(AW'(8 + 4 * i));
            check("R4 readback", rd0, 32'hA5A5_0000 + 32'(i));
        end
        for (int i = 0; i < N; i++) wr(0, AW'(8 + 4 * i), 32'h0);

        // R5: gaps and misaligned
        wr(0, 8'h04, 32'hFFFF_FFFF);
        wr(0, AW'(8 + 4 * N), 32'hFFFF_FFFF);
        wr(0, 8'h09, 32'hFFFF_FFFF);
        look(8'h04); check("R5 gap 0x4", rd0, 32'h0);
        look(AW'(8 + 4 * N)); check("R5 past end", rd0, 32'h0);
        look(8'h09); check("R5 misaligned", rd0, 32'h0);
        look(8'h08); check("R5 cmp0 untouched", rd0, 32'h0);
        look(8'h00); check("R5 ctrl untouched", rd0, exp_ctrl(0, 0));

        // R2: keyless write ignored, keyed write loads
        wr(0, 8'h00, 32'h0000_0001);
        look(8'h00); check("R2 keyless", rd0, exp_ctrl(0, 0));
        wr(0, 8'h00, 32'h0000_0003);
        wr(1, 8'h00, 32'h0000_0003);
        look(8'h00);
        check("R3 ctrl0 enabled", rd0, exp_ctrl(0, 1));
        check("R3 ctrl1 enabled", rd1, exp_ctrl(1, 1));

        // R6 example word
        wr(0, 8'h08, 32'h4800_09A5);
        fetch(1'b1, 32'h0800_09A4);
        check("R6 example hit", {31'b0, hit0}, 32'h1);

        // R6 sweep: selector x low two address bits, plus high-bit guard
        base = 32'h0800_09A4;
        for (int s = 0; s < 4; s++) begin
            c = (32'(s) << 30) | base | 32'h1;
            wr(0, 8'h08, c);
            for (int o = 0; o < 4; o++) begin
                fetch(1'b1, base | 32'(o));
                check("R6 sel sweep", {31'b0, hit0}, {31'b0, exp_narrow(c, base | 32'(o))});
                fetch(1'b1, base | 32'(o) | 32'h2000_0000);
                check("R6 high bits", {31'b0, hit0}, 32'h0);
            end
        end

        // R8: comparator enable, fetch_valid, global enable
        wr(0, 8'h08, 32'hC800_09A4);
        fetch(1'b1, base);
        check("R8 cmp disabled", {31'b0, hit0}, 32'h0);
        wr(0, 8'h08, 32'hC800_09A5);
        fetch(1'b0, base);
        check("R8 fetch invalid", {31'b0, hit0}, 32'h0);
        wr(0, 8'h00, 32'h0000_0000);
        fetch(1'b1, base);
        check("R8 keyless disable ignored", {31'b0, hit0}, 32'h1);
        wr(0, 8'h00, 32'h0000_0002);
        fetch(1'b1, base);
        check("R8 global off", {31'b0, hit0}, 32'h0);
        wr(0, 8'h00, 32'h0000_0003);

        // R9: lowest index
        wr(0, 8'h08, 32'h4000_1001);
        wr(0, 8'h0C, 32'hC000_2001);
        wr(0, 8'h14, 32'hC000_2001);
        fetch(1'b1, 32'h0000_2002);
        check("R9 hit", {31'b0, hit0}, 32'h1);
        check("R9 idx 1", {30'b0, idx0}, 32'h1);
        wr(0, 8'h0C, 32'h0);
        fetch(1'b1, 32'h0000_2002);
        check("R9 idx 3", {30'b0, idx0}, 32'h3);

        // R7: wide format sweep
        wr(1, 8'h10, 32'hC000_0011);
        for (int o = 0; o < 8; o++) begin
            fetch(1'b1, 32'hC000_000E + 32'(o));
            check("R7 wide sweep", {31'b0, hit1},
                  {31'b0, ((32'hC000_000E + 32'(o)) >> 1) == (32'hC000_0010 >> 1)});
            if (((32'hC000_000E + 32'(o)) >> 1) == (32'hC000_0010 >> 1))
                check("R7 wide idx", {30'b0, idx1}, 32'h2);
        end

        fetch(1'b0, 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule